// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based cache coherence scheme for a machine with a fixed number of processors. For every memory block it owns, it keeps a coherence state (Uncached, Shared or Exclusive), a presence vector with one bit per processor, and the block's data word. Requests from processor caches arrive one at a time on a valid/ready port. Each request carries a kind, the source processor, the block index and, for write-backs, data. The controller answers by emitting directed messages on a single output port, at most one message per cycle. The message kinds are data replies, invalidations, fetches, and combined fetch-and-invalidate requests.

Invalidations go only to the processors whose presence bit is set, never as a broadcast. When a block is held dirty by one owner, the controller recalls the data from that owner with a fetch. It then parks until the owner's write-back arrives, stores the data, and forwards it to the requester. The network, the cache-side controllers and buffer deadlock avoidance lie outside the block, and messages are taken to arrive in order.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and data zero; `req_ready` is 1 and `msg_valid` is 0.
- R2: Request kinds are 0 read miss, 1 write miss, 2 write-back. Message kinds are 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate. Non-reply messages carry data zero. A read miss from P to an Uncached block produces, in the cycle after acceptance, a data reply to P with the stored data, and the block becomes Shared with presence {P}.
- R3: A write miss from P to an Uncached block produces a data reply to P with the stored data, and the block becomes Exclusive, owned by P.
- R4: A read miss from P to a Shared block replies to P with the stored data and adds P to the presence vector, leaving it Shared.
- R5: A write miss from P to a Shared block sends one invalidate per cycle to every other sharer, in ascending processor index, skipping P. In the cycle after the last invalidate (or at once, if P was the only sharer) it sends the data reply to P, and the block becomes Exclusive, owned by P.
- R6: A read miss from P to an Exclusive block sends a fetch to the owner. Once the owner's write-back is accepted, the data is stored and is replied to P in the next cycle. The block becomes Shared with presence {owner, P}.
- R7: A write miss from P to an Exclusive block sends a fetch-and-invalidate to the owner. The owner's write-back data is stored and is forwarded to P, and the block becomes Exclusive, owned by P.
- R8: A write-back from the owner of an Exclusive block stores its data and makes the block Uncached with an empty vector; no message is produced.
- R9: A write-back from a processor that does not own the block in Exclusive state produces no message and leaves data and state unchanged.
- R10: While invalidates are being issued, `req_ready` is 0. While a recall is outstanding, `req_ready` is 0 for every request except the write-back from the recalled owner for that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | PW | Source processor index |
| req_blk | input | BW | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message present (one cycle) |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst | output | PW | Destination processor index |
| msg_blk | output | BW | Block index of the message |
| msg_data | output | DATA_W | Reply data, zero for other kinds |

## Verification
The bench goes after the presence vector through its visible effects. It sets up sharer sets with gaps and with the writer among the sharers. A design that broadcast, invalidated the requester, or walked the vector out of order would put the wrong destinations into the scoreboard. It also recalls dirty blocks with both read and write misses. A controller that replied with stale memory, kept the old owner as a sharer after a write, or dropped it after a read would show wrong data or wrong invalidate targets on later requests. Stray write-backs from non-owners and unrelated requests during a recall are driven too. A design that accepted them would emit unexpected messages, lose the stall, or corrupt data seen by the next reader.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DST_UNC = 2'd0,
    DST_SHR = 2'd1,
    DST_EXC = 2'd2
  } dir_st_e;

  typedef enum logic [1:0] {
    REQ_RD = 2'd0,
    REQ_WR = 2'd1,
    REQ_WB = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_REPLY = 2'd0,
    MSG_INV   = 2'd1,
    MSG_FETCH = 2'd2,
    MSG_FINV  = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INV  = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

endpackage

// File: rtl/coh_inv_pick.sv
module coh_inv_pick #(
  parameter int NPROC = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC-1:0] mask,
  output logic             any,
  output logic [PW-1:0]    idx,
  output logic [NPROC-1:0] rest
);

  function automatic logic [PW-1:0] first_one(input logic [NPROC-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  function automatic logic [NPROC-1:0] drop_lowest(input logic [NPROC-1:0] v);
    return v & (v - NPROC'(1));
  endfunction

  assign any  = |mask;
  assign idx  = first_one(mask);
  assign rest = drop_lowest(mask);

endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int NPROC = 4,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_idx,
  output dir_st_e          rd_st,
  output logic [NPROC-1:0] rd_sh,
  input  logic             we,
  input  logic [BW-1:0]    wr_idx,
  input  dir_st_e          wr_st,
  input  logic [NPROC-1:0] wr_sh
);

  dir_st_e          st_q [NBLK];
  logic [NPROC-1:0] sh_q [NBLK];

  assign rd_st = st_q[rd_idx];
  assign rd_sh = sh_q[rd_idx];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g] <= DST_UNC;
        sh_q[g] <= '0;
      end else if (we && wr_idx == BW'(g)) begin
        st_q[g] <= wr_st;
        sh_q[g] <= wr_sh;
      end
    end

    // R3
    excl_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DST_EXC) |-> ($countones(sh_q[g]) == 1));
    // R8
    unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DST_UNC) |-> (sh_q[g] == '0));
    // R4
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == DST_SHR) |-> (sh_q[g] != '0));
  end

endmodule

// File: rtl/coh_blk_mem.sv
module coh_blk_mem #(
  parameter int NBLK   = 8,
  parameter int DATA_W = 16,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [BW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem_q [NBLK];

  assign rd_data = mem_q[rd_idx];

  for (genvar g = 0; g < NBLK; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem_q[g] <= '0;
      else if (we && wr_idx == BW'(g))    mem_q[g] <= wr_data;
    end
  end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NBLK   = 8,
  parameter int DATA_W = 16,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [PW-1:0]     req_src,
  input  logic [BW-1:0]     req_blk,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [PW-1:0]     msg_dst,
  output logic [BW-1:0]     msg_blk,
  output logic [DATA_W-1:0] msg_data
);

  function automatic logic [NPROC-1:0] proc_bit(input logic [PW-1:0] p);
    logic [NPROC-1:0] b;
    b = '0;
    b[p] = 1'b1;
    return b;
  endfunction

  phase_e            phase_q, phase_n;
  logic [BW-1:0]     pend_blk_q;
  logic [PW-1:0]     pend_src_q, pend_own_q;
  logic              pend_wr_q, pend_wr_n;
  logic [NPROC-1:0]  inv_mask_q, inv_mask_n;
  logic              pend_load;

  req_kind_e         kind;
  logic [BW-1:0]     look_idx;
  dir_st_e           cur_st;
  logic [NPROC-1:0]  cur_sh;
  logic [DATA_W-1:0] cur_data;

  logic              tbl_we;
  dir_st_e           tbl_st_w;
  logic [NPROC-1:0]  tbl_sh_w;
  logic              mem_we;

  logic              emit;
  msg_kind_e         emit_kind;
  logic [PW-1:0]     emit_dst;
  logic [DATA_W-1:0] emit_data;

  logic              own_any, inv_any;
  logic [PW-1:0]     own_idx, inv_idx;
  logic [NPROC-1:0]  own_rest, inv_rest;

  // named events
  logic              acc;
  logic              wb_owner_hit;
  logic              recall_match;

  assign kind     = req_kind_e'(req_kind);
  assign look_idx = (phase_q == PH_IDLE) ? req_blk : pend_blk_q;
  assign acc      = req_valid && req_ready;
  assign wb_owner_hit = (kind == REQ_WB) && (cur_st == DST_EXC) && cur_sh[req_src];
  assign recall_match = (kind == REQ_WB) && (req_src == pend_own_q) && (req_blk == pend_blk_q);
  assign req_ready = (phase_q == PH_IDLE) || ((phase_q == PH_WAIT) && recall_match);

  coh_dir_table #(.NBLK(NBLK), .NPROC(NPROC)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_st(cur_st), .rd_sh(cur_sh),
    .we(tbl_we), .wr_idx(look_idx), .wr_st(tbl_st_w), .wr_sh(tbl_sh_w)
  );

  coh_blk_mem #(.NBLK(NBLK), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_data(cur_data),
    .we(mem_we), .wr_idx(look_idx), .wr_data(req_data)
  );

  coh_inv_pick #(.NPROC(NPROC)) u_owner (
    .mask(cur_sh), .any(own_any), .idx(own_idx), .rest(own_rest)
  );

  coh_inv_pick #(.NPROC(NPROC)) u_inv (
    .mask(inv_mask_q), .any(inv_any), .idx(inv_idx), .rest(inv_rest)
  );

  always_comb begin
    phase_n    = phase_q;
    pend_load  = 1'b0;
    pend_wr_n  = pend_wr_q;
    inv_mask_n = inv_mask_q;
    tbl_we     = 1'b0;
    tbl_st_w   = cur_st;
    tbl_sh_w   = cur_sh;
    mem_we     = 1'b0;
    emit       = 1'b0;
    emit_kind  = MSG_REPLY;
    emit_dst   = req_src;
    emit_data  = cur_data;
    unique case (phase_q)
      PH_IDLE: begin
        if (acc) begin
          unique case (kind)
            REQ_RD: begin
              if (cur_st == DST_EXC) begin
                emit      = 1'b1;
                emit_kind = MSG_FETCH;
                emit_dst  = own_idx;
                emit_data = '0;
                pend_load = 1'b1;
                pend_wr_n = 1'b0;
                phase_n   = PH_WAIT;
              end else begin
                tbl_we   = 1'b1;
                tbl_st_w = DST_SHR;
                tbl_sh_w = cur_sh | proc_bit(req_src);
                emit     = 1'b1;
              end
            end
            REQ_WR: begin
              if (cur_st == DST_EXC) begin
                emit      = 1'b1;
                emit_kind = MSG_FINV;
                emit_dst  = own_idx;
                emit_data = '0;
                pend_load = 1'b1;
                pend_wr_n = 1'b1;
                phase_n   = PH_WAIT;
              end else if (cur_st == DST_SHR) begin
                pend_load  = 1'b1;
                inv_mask_n = cur_sh & ~proc_bit(req_src);
                phase_n    = PH_INV;
              end else begin
                tbl_we   = 1'b1;
                tbl_st_w = DST_EXC;
                tbl_sh_w = proc_bit(req_src);
                emit     = 1'b1;
              end
            end
            REQ_WB: begin
              if (wb_owner_hit) begin
                tbl_we   = 1'b1;
                tbl_st_w = DST_UNC;
                tbl_sh_w = '0;
                mem_we   = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      PH_INV: begin
        emit = 1'b1;
        if (inv_any) begin
          emit_kind  = MSG_INV;
          emit_dst   = inv_idx;
          emit_data  = '0;
          inv_mask_n = inv_rest;
        end else begin
          emit_dst = pend_src_q;
          tbl_we   = 1'b1;
          tbl_st_w = DST_EXC;
          tbl_sh_w = proc_bit(pend_src_q);
          phase_n  = PH_IDLE;
        end
      end
      PH_WAIT: begin
        if (acc) begin
          mem_we    = 1'b1;
          tbl_we    = 1'b1;
          tbl_st_w  = pend_wr_q ? DST_EXC : DST_SHR;
          tbl_sh_w  = pend_wr_q ? proc_bit(pend_src_q)
                                : (proc_bit(pend_src_q) | proc_bit(pend_own_q));
          emit      = 1'b1;
          emit_dst  = pend_src_q;
          emit_data = req_data;
          phase_n   = PH_IDLE;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      pend_blk_q <= '0;
      pend_src_q <= '0;
      pend_own_q <= '0;
      pend_wr_q  <= 1'b0;
      inv_mask_q <= '0;
    end else begin
      phase_q    <= phase_n;
      pend_wr_q  <= pend_wr_n;
      inv_mask_q <= inv_mask_n;
      if (pend_load) begin
        pend_blk_q <= req_blk;
        pend_src_q <= req_src;
        pend_own_q <= own_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_kind  <= 2'd0;
      msg_dst   <= '0;
      msg_blk   <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= emit;
      if (emit) begin
        msg_kind <= emit_kind;
        msg_dst  <= emit_dst;
        msg_blk  <= look_idx;
        msg_data <= emit_data;
      end
    end
  end

  // R5
  inv_skips_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MSG_INV) |-> (msg_dst != pend_src_q));
  // R5
  inv_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MSG_INV && $past(msg_valid && msg_kind == MSG_INV))
      |-> (msg_dst > $past(msg_dst)));
  // R6
  recall_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && acc)
      |=> (msg_valid && msg_kind == MSG_REPLY && msg_dst == $past(pend_src_q)
           && msg_data == $past(req_data)));
  // R10
  fetch_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_kind == MSG_FETCH || msg_kind == MSG_FINV)) |-> (phase_q == PH_WAIT));
  // R10
  recall_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && req_valid && req_src != pend_own_q) |-> !req_ready);

endmodule

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;

  localparam int PW = 2;
  localparam int BW = 3;
  localparam int DW = 16;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] M_REP = 2'd0, M_INV = 2'd1, M_FET = 2'd2, M_FIN = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [PW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic          msg_valid;
  logic [1:0]    msg_kind;
  logic [PW-1:0] msg_dst;
  logic [BW-1:0] msg_blk;
  logic [DW-1:0] msg_data;

  always #10 clk = ~clk;

  coh_home_dir #(.NPROC(4), .NBLK(8), .DATA_W(DW)) i_coh_home_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .msg_blk(msg_blk), .msg_data(msg_data)
  );

  typedef struct packed {
    logic [1:0]    kind;
    logic [PW-1:0] dst;
    logic [BW-1:0] blk;
    logic [DW-1:0] data;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int    nvec = 0;
  int    nbad = 0;
  bit    done = 1'b0;

  task automatic expect_msg(input logic [1:0] k, input int d, input int b,
                            input logic [DW-1:0] v, input string tag);
    item_t it;
    it.kind = k; it.dst = PW'(d); it.blk = BW'(b); it.data = v;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && !done) begin
      item_t got, want;
      string tag;
      got = {msg_kind, msg_dst, msg_blk, msg_data};
      nvec++;
      if (exp_q.size() == 0) begin
        nbad++;
        $display("FAIL R9 unexpected message got %h expected none", got);
      end else begin
        want = exp_q.pop_front();
        tag  = tag_q.pop_front();
        if (got !== want) begin
          nbad++;
          $display("FAIL %s got %h expected %h", tag, got, want);
        end
      end
    end
  end

  task automatic send(input logic [1:0] k, input int s, input int b, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = PW'(s); req_blk = BW'(b); req_data = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic check_stall(input logic [1:0] k, input int s, input int b, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = PW'(s); req_blk = BW'(b); req_data = 16'hDEAD;
    #1;
    nvec++;
    if (req_ready !== 1'b0) begin
      nbad++;
      $display("FAIL %s req_ready got %b expected 0", tag, req_ready);
    end
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    nvec++;
    if (req_ready !== 1'b1 || msg_valid !== 1'b0) begin
      nbad++;
      $display("FAIL R1 ready/valid got %b%b expected 10", req_ready, msg_valid);
    end

    // block 0: sharers built up, then write with others present
    expect_msg(M_REP, 1, 0, 16'h0000, "R2");
    send(K_RD, 1, 0, 0);
    expect_msg(M_REP, 2, 0, 16'h0000, "R4");
    send(K_RD, 2, 0, 0);
    expect_msg(M_REP, 0, 0, 16'h0000, "R4");
    send(K_RD, 0, 0, 0);
    expect_msg(M_INV, 0, 0, 16'h0000, "R5");
    expect_msg(M_INV, 1, 0, 16'h0000, "R5");
    expect_msg(M_REP, 2, 0, 16'h0000, "R5");
    send(K_WR, 2, 0, 0);
    check_stall(K_RD, 3, 4, "R10 invalidate phase");
    send(K_WB, 2, 0, 16'h00AA);                 // R8 owner write-back, no message
    expect_msg(M_REP, 3, 0, 16'h00AA, "R8");
    send(K_RD, 3, 0, 0);
    send(K_WB, 3, 0, 16'h5555);                 // R9 stray in Shared
    expect_msg(M_REP, 1, 0, 16'h00AA, "R9");
    send(K_RD, 1, 0, 0);
    expect_msg(M_INV, 1, 0, 16'h0000, "R5");
    expect_msg(M_INV, 3, 0, 16'h0000, "R5");
    expect_msg(M_REP, 0, 0, 16'h00AA, "R5");
    send(K_WR, 0, 0, 0);

    // block 1: exclusive recalls
    expect_msg(M_REP, 0, 1, 16'h0000, "R3");
    send(K_WR, 0, 1, 0);
    send(K_WB, 2, 1, 16'h1234);                 // R9 non-owner write-back
    expect_msg(M_FET, 0, 1, 16'h0000, "R6");
    send(K_RD, 3, 1, 0);
    check_stall(K_RD, 1, 2, "R10 recall other block");
    check_stall(K_WB, 2, 1, "R10 recall wrong source");
    expect_msg(M_REP, 3, 1, 16'h0BEE, "R6");
    send(K_WB, 0, 1, 16'h0BEE);
    expect_msg(M_INV, 0, 1, 16'h0000, "R6");
    expect_msg(M_INV, 3, 1, 16'h0000, "R6");
    expect_msg(M_REP, 1, 1, 16'h0BEE, "R6");
    send(K_WR, 1, 1, 0);
    expect_msg(M_FIN, 1, 1, 16'h0000, "R7");
    send(K_WR, 2, 1, 0);
    expect_msg(M_REP, 2, 1, 16'h0C0D, "R7");
    send(K_WB, 1, 1, 16'h0C0D);
    send(K_WB, 1, 1, 16'h7777);                 // R9 old owner after handover
    send(K_WB, 2, 1, 16'h0777);                 // R8
    expect_msg(M_REP, 0, 1, 16'h0777, "R8");
    send(K_RD, 0, 1, 0);

    // block 3: requester is the only sharer
    expect_msg(M_REP, 1, 3, 16'h0000, "R2");
    send(K_RD, 1, 3, 0);
    expect_msg(M_REP, 1, 3, 16'h0000, "R5");
    send(K_WR, 1, 3, 0);

    // block 7: untouched since reset
    expect_msg(M_REP, 0, 7, 16'h0000, "R1");
    send(K_RD, 0, 7, 0);

    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    nvec++;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL R2 pending messages got %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule